// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers interrupt requests from 31 external sources, numbered 1 to 31, and steers them to two target contexts. ID 0 is reserved and means "no interrupt". Each source has a 3-bit priority. Each context has its own set of enable bits, a 3-bit threshold, and one claim/complete register. A context's interrupt line is raised while at least one pending source is enabled for it and has a priority strictly above its threshold.

A source is delivered in two steps. Software reads the context's claim register, which returns the winning ID and takes that source out of pending in the same access. When the handler is done, it writes the ID back to the same register to complete it. Between the claim and the completion, the source's gateway holds back further requests. Sources 1 to 15 are level-high, and their pending bit follows the line while they are idle. Sources 16 to 31 are rising-edge: an edge sets pending, and one edge that arrives while the source is claimed is remembered and delivered after completion.

Access is through a simple 32-bit word bus with one transfer per cycle. Read data appears on `bus_rdata` in the cycle after the request.

Top module: `prio_intc`

## Requirements
- R1: After reset, all priorities, enable bits and thresholds read 0, claim reads return 0, and `ctx_irq` is low.
- R2: The priority of source k is read and written at byte offset 4*k. Only bits [2:0] are stored. Offset 0 always reads 0 and ignores writes.
- R3: The enable word of context c is at 0x2000 + 0x80*c. Bit k of that word enables source k, and bit 0 always reads 0.
- R4: The threshold of context c is at 0x200000 + 0x1000*c, bits [2:0] only. The claim/complete register of context c is at 0x200004 + 0x1000*c.
- R5: `ctx_irq[c]` goes high two clock edges after a pending, enabled source with priority strictly greater than the threshold of context c appears. It is never high for priority-0 sources alone, and never high while the threshold is 7.
- R6: A claim read returns the ID of the eligible source with the highest priority. Among equal priorities the lowest ID wins. When no source is eligible, the read returns 0.
- R7: A claim clears the source's pending bit. The source is not returned by any claim until it has been completed.
- R8: Level sources (IDs 1 to 15) are pending while their line is high and they are not claimed. If the line is still high after completion, the source becomes pending again.
- R9: Edge sources (IDs 16 to 31) become pending on a rising edge. A rising edge seen while the source is claimed is delivered after completion. A line that stays high does not re-trigger.
- R10: A completion write is ignored if the written ID is not currently claimed by that same context, or if that source is not enabled for that context.
- R11: The pending bits are read at 0x1000, with bit k for source k. Writes to this word have no effect.
- R12: Reads of unmapped or misaligned addresses return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 31 | Interrupt lines; bit k is source k (1..31) |
| bus_req | input | 1 | Bus transfer request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 22 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| ctx_irq | output | 2 | Interrupt line per context |

## Verification
A wrong pending or claimed flag shows up at the next claim read of any context enabled for that source. A stuck flag makes the ID come back twice or never. A lost edge shows as a 0 where a post-completion claim should return the ID. A wrong arbitration result appears in the very next claim read data, and a wrong eligibility decision shows on `ctx_irq` two edges after the inputs change. Completion filtering errors show as a source that re-appears, or stays blocked, at the first claim read after the bad write.

// File: rtl/prio_intc_pkg.sv
// Shared address map constants and register-kind decode type for prio_intc.
// Assumes word-aligned 32-bit accesses; offsets are byte addresses.
package prio_intc_pkg;
    localparam logic [31:0] PRIO_BASE  = 32'h0000_0000;
    localparam logic [31:0] PEND_BASE  = 32'h0000_1000;
    localparam logic [31:0] EN_BASE    = 32'h0000_2000;
    localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
    localparam logic [31:0] CTL_BASE   = 32'h0020_0000;
    localparam logic [31:0] CTL_STRIDE = 32'h0000_1000;
    localparam logic [31:0] THR_OFS    = 32'h0000_0000;
    localparam logic [31:0] CLAIM_OFS  = 32'h0000_0004;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_PRIO,
        RK_PEND,
        RK_EN,
        RK_THR,
        RK_CLAIM
    } reg_kind_e;
endpackage

// File: rtl/prio_intc_gateway.sv
// Per-source request gateway. Turns a level or rising-edge line into a
// pending flag, and blocks new requests between claim and completion.
// Assumes claim_i and done_i are never high in the same cycle.
module prio_intc_gateway #(
    parameter bit EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic claim_i,
    input  logic done_i,
    output logic pend_o,
    output logic busy_o
);
    logic prev_q;
    logic held_q;
    logic rise;

    assign rise = src_i & ~prev_q;

    // Track the pending, claimed and held-edge state of one source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            held_q <= 1'b0;
            pend_o <= 1'b0;
            busy_o <= 1'b0;
        end else begin
            prev_q <= src_i;
            if (claim_i) begin
                pend_o <= 1'b0;
                busy_o <= 1'b1;
                held_q <= EDGE & rise;
            end else if (done_i) begin
                busy_o <= 1'b0;
                pend_o <= EDGE ? (held_q | rise) : src_i;
                held_q <= 1'b0;
            end else if (busy_o) begin
                if (EDGE && rise) held_q <= 1'b1;
            end else begin
                pend_o <= EDGE ? (pend_o | rise) : src_i;
            end
        end
    end
endmodule

// File: rtl/prio_intc_arbiter.sv
// Per-context arbiter. Picks the pending, enabled source whose priority is
// strictly above the threshold and highest of all; the lowest ID wins ties.
// Purely combinational; returns 0 when nothing qualifies.
module prio_intc_arbiter #(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 5
) (
    input  logic [NSRC:1]             pend_i,
    input  logic [NSRC:1]             en_i,
    input  logic [NSRC:1][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         thr_i,
    output logic [ID_W-1:0]           best_o
);
    logic [PRIO_W-1:0] best_p;

    // Scan upward; only a strictly higher priority replaces the current pick.
    always_comb begin
        best_o = '0;
        best_p = thr_i;
        for (int k = 1; k <= NSRC; k++) begin
            if (pend_i[k] && en_i[k] && (prio_i[k] > best_p)) begin
                best_p = prio_i[k];
                best_o = ID_W'(k);
            end
        end
    end
endmodule

// File: rtl/prio_intc.sv
// Prioritised interrupt controller top. Holds the priority, enable and
// threshold registers, decodes the word bus, and runs claim/complete.
// Assumes one bus transfer per cycle; read data is registered.
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NSRC       = 31,
    parameter int NCTX       = 2,
    parameter int PRIO_W     = 3,
    parameter int ADDR_W     = 22,
    parameter int EDGE_FIRST = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC:1]     src_i,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCTX-1:0]   ctx_irq
);
    localparam int ID_W  = $clog2(NSRC + 1);
    localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1;
    localparam int NWORD = NSRC / 32 + 1;

    logic [NSRC:1][PRIO_W-1:0]  prio_q;
    logic [NCTX-1:0][NSRC:1]    en_q;
    logic [NCTX-1:0][PRIO_W-1:0] thr_q;
    logic [NSRC:1][CTX_W-1:0]   owner_q;
    logic [NSRC:1]              pend_q, busy_q, claim_v, done_v;
    logic [NCTX-1:0][ID_W-1:0]  best_id;

    reg_kind_e   kind;
    logic [31:0] a, rel, sel_idx, sel_word;
    logic [CTX_W-1:0] ctx_sel;
    logic [31:0] rd_data;
    logic        rd, wr;

    assign rd = bus_req & ~bus_we;
    assign wr = bus_req & bus_we;

    // Classify the bus address and extract context, word and source index.
    always_comb begin
        a        = 32'(bus_addr);
        kind     = RK_NONE;
        rel      = '0;
        sel_idx  = '0;
        sel_word = '0;
        ctx_sel  = '0;
        if (a[1:0] == 2'b00) begin
            if (a < PEND_BASE) begin
                sel_idx = (a - PRIO_BASE) >> 2;
                if (sel_idx <= 32'(NSRC)) kind = RK_PRIO;
            end else if (a < PEND_BASE + 32'(4 * NWORD)) begin
                kind     = RK_PEND;
                sel_word = (a - PEND_BASE) >> 2;
            end else if (a >= EN_BASE && a < EN_BASE + 32'(NCTX) * EN_STRIDE) begin
                rel      = a - EN_BASE;
                ctx_sel  = CTX_W'(rel / EN_STRIDE);
                sel_word = (rel % EN_STRIDE) >> 2;
                if (sel_word < 32'(NWORD)) kind = RK_EN;
            end else if (a >= CTL_BASE && a < CTL_BASE + 32'(NCTX) * CTL_STRIDE) begin
                rel     = a - CTL_BASE;
                ctx_sel = CTX_W'(rel / CTL_STRIDE);
                if ((rel % CTL_STRIDE) == THR_OFS)   kind = RK_THR;
                if ((rel % CTL_STRIDE) == CLAIM_OFS) kind = RK_CLAIM;
            end
        end
    end

    // Claim pulses follow the addressed context's winner; completions are filtered.
    always_comb begin
        for (int k = 1; k <= NSRC; k++) begin
            claim_v[k] = rd && (kind == RK_CLAIM) && (best_id[ctx_sel] == ID_W'(k));
            done_v[k]  = wr && (kind == RK_CLAIM) && (bus_wdata == 32'(k)) &&
                         busy_q[k] && (owner_q[k] == ctx_sel) && en_q[ctx_sel][k];
        end
    end

    // Read multiplexer; unmapped locations and reserved bits return 0.
    always_comb begin
        rd_data = '0;
        unique case (kind)
            RK_PRIO: begin
                for (int k = 1; k <= NSRC; k++)
                    if (sel_idx == 32'(k)) rd_data = 32'(prio_q[k]);
            end
            RK_PEND: begin
                for (int k = 1; k <= NSRC; k++)
                    if (sel_word == 32'(k / 32)) rd_data[5'(k % 32)] = pend_q[k];
            end
            RK_EN: begin
                for (int k = 1; k <= NSRC; k++)
                    if (sel_word == 32'(k / 32)) rd_data[5'(k % 32)] = en_q[ctx_sel][k];
            end
            RK_THR:   rd_data = 32'(thr_q[ctx_sel]);
            RK_CLAIM: rd_data = 32'(best_id[ctx_sel]);
            default:  rd_data = '0;
        endcase
    end

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (wr) begin
            if (kind == RK_PRIO)
                for (int k = 1; k <= NSRC; k++)
                    if (sel_idx == 32'(k)) prio_q[k] <= bus_wdata[PRIO_W-1:0];
            if (kind == RK_EN)
                for (int k = 1; k <= NSRC; k++)
                    if (sel_word == 32'(k / 32)) en_q[ctx_sel][k] <= bus_wdata[5'(k % 32)];
            if (kind == RK_THR) thr_q[ctx_sel] <= bus_wdata[PRIO_W-1:0];
        end
    end

    // Remember which context claimed each source; register read data and outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q   <= '0;
            bus_rdata <= '0;
            ctx_irq   <= '0;
        end else begin
            for (int k = 1; k <= NSRC; k++)
                if (claim_v[k]) owner_q[k] <= ctx_sel;
            if (rd) bus_rdata <= rd_data;
            for (int c = 0; c < NCTX; c++)
                ctx_irq[c] <= (best_id[c] != '0);
        end
    end

    for (genvar k = 1; k <= NSRC; k++) begin : g_gw
        prio_intc_gateway #(.EDGE((k >= EDGE_FIRST) ? 1'b1 : 1'b0)) u_gw (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (src_i[k]),
            .claim_i (claim_v[k]),
            .done_i  (done_v[k]),
            .pend_o  (pend_q[k]),
            .busy_o  (busy_q[k])
        );
    end

    for (genvar c = 0; c < NCTX; c++) begin : g_arb
        prio_intc_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
            .pend_i (pend_q),
            .en_i   (en_q[c]),
            .prio_i (prio_q),
            .thr_i  (thr_q[c]),
            .best_o (best_id[c])
        );
    end
endmodule

// File: rtl/prio_intc_chk.sv
// Assertion checker for prio_intc, attached by bind below. Observes the bus,
// the outputs, and the gateway and threshold state of the design.
module prio_intc_chk
    import prio_intc_pkg::*;
#(
    parameter int NSRC   = 31,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 22,
    parameter int ID_W   = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_req,
    input logic                       bus_we,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [31:0]                bus_rdata,
    input logic [NCTX-1:0]            ctx_irq,
    input logic [NSRC:1]              pend,
    input logic [NSRC:1]              busy,
    input logic [NCTX-1:0][PRIO_W-1:0] thr
);
    logic rd_claim, rd_claim_q;
    logic [ID_W-1:0] got_id;

    assign got_id = bus_rdata[ID_W-1:0];

    // Spot a read of any context's claim register.
    always_comb begin
        rd_claim = 1'b0;
        for (int c = 0; c < NCTX; c++)
            if (bus_req && !bus_we &&
                32'(bus_addr) == CTL_BASE + 32'(c) * CTL_STRIDE + CLAIM_OFS)
                rd_claim = 1'b1;
    end

    // Delay the claim-read flag to line up with the returned data.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_claim_q <= 1'b0;
        else        rd_claim_q <= rd_claim;
    end

    AST_CLAIMED_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_claim_q && got_id != '0) |-> busy[got_id]); // R7

    AST_CLAIMED_NOT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_claim_q && got_id != '0) |-> !pend[got_id]); // R7

    AST_PEND_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & busy) == '0); // R7

    AST_ID0_PRIO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr == '0) |=> bus_rdata == '0); // R2

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ctx_irq[c]) |-> $past(pend != '0)); // R5

        AST_THR_MAX_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
            $past(thr[c] == {PRIO_W{1'b1}}) |-> !ctx_irq[c]); // R5
    end
endmodule

bind prio_intc prio_intc_chk #(
    .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .ID_W(ID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .ctx_irq   (ctx_irq),
    .pend      (pend_q),
    .busy      (busy_q),
    .thr       (thr_q)
);

// File: tb/prio_intc_tb.sv
// Self-checking bench for prio_intc: arbitration vector table, then directed tests.
module prio_intc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:1] lines = '0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [21:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  ctx_irq;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    prio_intc u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(lines),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctx_irq(ctx_irq)
    );

    localparam logic [21:0] CLM0 = 22'h200004;
    localparam logic [21:0] CLM1 = 22'h201004;
    localparam logic [21:0] THR0 = 22'h200000;
    localparam logic [21:0] THR1 = 22'h201000;
    localparam logic [21:0] EN0  = 22'h002000;
    localparam logic [21:0] EN1  = 22'h002080;
    localparam logic [21:0] PND  = 22'h001000;

    // Priorities of sources 1..8
    localparam logic [2:0] PRI [1:8] = '{3'd3, 3'd5, 3'd5, 3'd7, 3'd1, 3'd0, 3'd2, 3'd7};
    // {lines[8:1], threshold[2:0], expected claim ID[4:0]}
    localparam logic [15:0] VECS [0:9] = '{
        16'h0101, 16'h0602, 16'h0382, 16'h02A0, 16'h2000,
        16'h88C4, 16'h5027, 16'hFFE0, 16'h1101, 16'h0000
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [21:0] ad, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = ad; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [21:0] ad, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = ad;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int id);
        @(negedge clk); lines[id] = 1'b1;
        @(negedge clk); lines[id] = 1'b0;
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        waitn(4);
        rst_n = 1'b1;
        waitn(1);

        // R1 reset state
        chk("R1 irq", 32'(ctx_irq), 32'h0);
        rd(22'h4, rv);  chk("R1 prio1", rv, 0);
        rd(EN0, rv);    chk("R1 en0", rv, 0);
        rd(THR0, rv);   chk("R1 thr0", rv, 0);
        rd(CLM0, rv);   chk("R1 claim0", rv, 0);

        for (int k = 1; k <= 8; k++) wr(22'(4 * k), 32'(PRI[k]));
        wr(EN0, 32'h1FE);
        rd(EN0, rv); chk("R3 en0 readback", rv, 32'h1FE);

        // R3 enable word of ctx1, bit 0 reserved
        wr(EN1, 32'hFFFF_FFFF);
        rd(EN1, rv); chk("R3 en1 bit0 zero", rv, 32'hFFFF_FFFE);
        wr(EN1, 0);
        // R2 priority width and reserved ID 0
        wr(22'h0, 7);
        rd(22'h0, rv);  chk("R2 id0 reads 0", rv, 0);
        wr(22'h7C, 32'hFFFF_FFFF);
        rd(22'h7C, rv); chk("R2 prio31 3 bits", rv, 7);
        wr(22'h7C, 0);
        rd(22'hC, rv);  chk("R2 prio3", rv, 5);
        // R4 threshold width and location
        wr(THR1, 32'hFFFF_FFFD);
        rd(THR1, rv); chk("R4 thr1", rv, 5);
        wr(THR1, 0);

        // R5/R6 arbitration table on ctx0
        for (int i = 0; i < 10; i++) begin
            wr(THR0, 32'(VECS[i][7:5]));
            lines[8:1] = VECS[i][15:8];
            waitn(3);
            chk($sformatf("R5 irq vec%0d", i), 32'(ctx_irq[0]), 32'(VECS[i][4:0] != 0));
            rd(CLM0, rv);
            chk($sformatf("R6 claim vec%0d", i), rv, 32'(VECS[i][4:0]));
            lines[8:1] = '0;
            if (VECS[i][4:0] != 0) wr(CLM0, 32'(VECS[i][4:0]));
            waitn(3);
        end
        wr(THR0, 0);

        // R7 gating and R10 completion filtering on source 1
        lines[1] = 1'b1; waitn(3);
        rd(CLM0, rv); chk("R7 first claim", rv, 1);
        rd(CLM0, rv); chk("R7 gated claim", rv, 0);
        rd(PND, rv);  chk("R7 pending cleared", rv, 0);
        waitn(2);     chk("R7 irq low while claimed", 32'(ctx_irq[0]), 0);
        wr(CLM0, 2); waitn(2);
        rd(CLM0, rv); chk("R10 wrong id ignored", rv, 0);
        wr(CLM1, 1); waitn(2);
        rd(CLM0, rv); chk("R10 other ctx ignored", rv, 0);
        wr(EN0, 32'h1FC); wr(CLM0, 1); wr(EN0, 32'h1FE); waitn(2);
        rd(CLM0, rv); chk("R10 disabled ignored", rv, 0);
        wr(CLM0, 1); waitn(2);
        rd(CLM0, rv); chk("R8 level re-pends", rv, 1);
        lines[1] = 1'b0;
        wr(CLM0, 1); waitn(2);
        rd(PND, rv);  chk("R8 low line not pending", rv, 0);

        // R9 edge source 20 and R11 pending word
        wr(22'h50, 4);
        wr(EN0, 32'h0010_01FE);
        pulse(20); waitn(2);
        rd(PND, rv); chk("R9 edge pends", rv, 32'h0010_0000);
        wr(PND, 0);
        rd(PND, rv); chk("R11 pending read-only", rv, 32'h0010_0000);
        rd(CLM0, rv); chk("R9 claim edge", rv, 20);
        pulse(20); waitn(2);
        rd(CLM0, rv); chk("R9 held while claimed", rv, 0);
        wr(CLM0, 20); waitn(2);
        rd(CLM0, rv); chk("R9 held edge delivered", rv, 20);
        wr(CLM0, 20);
        @(negedge clk); lines[20] = 1'b1; waitn(2);
        rd(CLM0, rv); chk("R9 new edge", rv, 20);
        wr(CLM0, 20); waitn(3);
        rd(CLM0, rv); chk("R9 steady high no retrigger", rv, 0);
        lines[20] = 1'b0;

        // R12 unmapped and misaligned
        rd(22'h3000, rv);   chk("R12 unmapped read", rv, 0);
        rd(22'h200008, rv); chk("R12 ctl gap read", rv, 0);
        rd(22'h000006, rv); chk("R12 misaligned read", rv, 0);
        wr(22'h3000, 32'hFFFF_FFFF);
        wr(22'h202000, 7);
        wr(22'h000006, 7);
        rd(22'h4, rv);  chk("R12 prio1 untouched", rv, 3);
        rd(THR0, rv);   chk("R12 thr0 untouched", rv, 0);
        rd(THR1, rv);   chk("R12 thr1 untouched", rv, 0);

        // R5/R10 second context owns source 2
        wr(EN1, 32'h4);
        lines[2] = 1'b1; waitn(3);
        chk("R5 ctx1 irq", 32'(ctx_irq[1]), 1);
        rd(CLM1, rv); chk("R6 ctx1 claim", rv, 2);
        rd(CLM0, rv); chk("R7 ctx0 sees none", rv, 0);
        lines[2] = 1'b0;
        wr(CLM0, 2); waitn(2);
        rd(PND, rv); chk("R10 non-owner completion ignored", rv, 0);
        wr(CLM1, 2); waitn(3);
        chk("R5 irq idle", 32'(ctx_irq), 0);

        finish_run();
    end
endmodule